// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds the software-visible configuration of a 24-pin I/O interrupt controller. Software reaches it through two offsets on a small synchronous bus. It first writes a register selector, then reads or writes a 32-bit data window. The selector picks one of three fixed registers (identification, version, arbitration) or one half of a 64-bit redirection entry. Each pin has one entry.

Every entry is exported in parallel to the delivery logic. The delivery logic owns the remote-IRR bit: it sets the bit when it delivers a level interrupt and clears it on end-of-interrupt. Software writes cannot overwrite the hardware-owned status bits. When an entry write leaves a pin level-triggered and unmasked while that pin's latched line is high, the block raises a one-cycle re-evaluate request so that the delivery logic retries the pin.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset, every entry reads as masked (bit 16 = 1) with all other bits 0. The selector, `rdata_o` and `reeval_o` are all 0.
- R2: A write to offset 0x00 stores `wdata_i[7:0]` as the selector, and a read of offset 0x00 returns it zero-extended. Offset 0x04 reads 0 and ignores writes. Any offset other than 0x00 or 0x10 reads 0.
- R3: `rdata_o` takes the read value on the clock edge that samples `re_i` high, and holds its value in every cycle without a read.
- R4: Selector 0x00 is the ID register: only bits [27:24] are stored and all other bits read 0. Selector 0x01 reads the constant 0x00170011 (maximum entry index NUM_PINS−1 in [23:16], version 0x11 in [7:0]). Selector 0x02 reads 0. Writes to selectors 0x01 and 0x02 are ignored.
- R5: The low word of pin n's entry is at selector 0x10+2n, and the high word is at the next odd selector. The fields are: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16], destination [63:56]. Entry n appears on `entries_o[n]`.
- R6: Bits [55:17] of every entry always read 0.
- R7: A low-word write cannot change delivery status (always 0) or remote IRR. If the written trigger bit is level, remote IRR keeps its hardware value.
- R8: A low-word write with trigger bit 0 (edge) clears remote IRR.
- R9: Window writes to selectors 0x03–0x0F, or to any selector whose pin index is NUM_PINS or more, change nothing, and reads of these selectors return 0.
- R10: `rirr_set_i[n]` sets and `rirr_clr_i[n]` clears remote IRR of pin n on the next edge; set wins when both are high. If a low-word write hits the same pin in the same cycle, R7 and R8 apply to the hardware-updated value.
- R11: After an entry write (either half) that leaves pin n level-triggered and unmasked while `line_lvl_i[n]` is 1, `reeval_o[n]` is 1 for exactly the next cycle. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus byte offset |
| wdata_i | input | 32 | Bus write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| line_lvl_i | input | NUM_PINS | Latched line level per pin |
| rirr_set_i | input | NUM_PINS | Remote-IRR set from delivery logic |
| rirr_clr_i | input | NUM_PINS | Remote-IRR clear from delivery logic |
| entries_o | output | NUM_PINS×64 | All redirection entries |
| reeval_o | output | NUM_PINS | One-cycle re-evaluate request per pin |

## Verification
The two functions that can meet in one cycle are a hardware remote-IRR update and a software low-word write to the same entry. The bench drives a remote-IRR set pulse on the very edge that writes a pin's low word. It does this once with the trigger bit level and once with it edge. The resulting remote-IRR bit is then judged on the exported entry: it must read 1 after the level write and 0 after the edge write.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_PAD  = 8'h04;
  localparam logic [7:0] OFF_WIN  = 8'h10;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_BASE = 8'h10;

  localparam logic [7:0] VER_CODE = 8'h11;

  localparam int unsigned LO_W    = 17;
  localparam int unsigned B_DSTAT = 12;
  localparam int unsigned B_RIRR  = 14;
  localparam int unsigned B_TRIG  = 15;
  localparam int unsigned B_MASK  = 16;
  localparam int unsigned RSV_W   = 39;
  localparam int unsigned DEST_W  = 8;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic [7:0]       sel_i,
  output logic             id_o,
  output logic             ver_o,
  output logic             arb_o,
  output logic             ent_o,
  output logic             hi_o,
  output logic [PIN_W-1:0] pin_o
);
  logic [7:0] rel;
  logic [6:0] idx;

  always_comb begin
    rel   = sel_i - SEL_BASE;
    idx   = rel[7:1];
    id_o  = (sel_i == SEL_ID);
    ver_o = (sel_i == SEL_VER);
    arb_o = (sel_i == SEL_ARB);
    ent_o = (sel_i >= SEL_BASE) && (int'(idx) < int'(NUM_PINS));
    hi_o  = sel_i[0];
    pin_o = idx[PIN_W-1:0];
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  input  logic        line_i,
  output logic [63:0] ent_o,
  output logic        reeval_o
);
  logic [LO_W-1:0]   lo_q, lo_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              rirr_hw, reeval_d;

  always_comb begin
    rirr_hw      = rirr_set_i | (lo_q[B_RIRR] & ~rirr_clr_i);
    lo_d         = lo_q;
    lo_d[B_RIRR] = rirr_hw;
    if (wr_lo_i) begin
      lo_d          = wdata_i[LO_W-1:0];
      lo_d[B_DSTAT] = 1'b0;
      // level keeps hardware state, edge clears it
      lo_d[B_RIRR]  = wdata_i[B_TRIG] & rirr_hw;
    end
    dest_d   = wr_hi_i ? wdata_i[31:32-DEST_W] : dest_q;
    reeval_d = (wr_lo_i | wr_hi_i) & lo_d[B_TRIG] & ~lo_d[B_MASK] & line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= LO_W'(1) << B_MASK;
      dest_q   <= '0;
      reeval_o <= 1'b0;
    end else begin
      lo_q     <= lo_d;
      dest_q   <= dest_d;
      reeval_o <= reeval_d;
    end
  end

  assign ent_o = {dest_q, {RSV_W{1'b0}}, lo_q};

  a_r8_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wdata_i[B_TRIG]) |=> !ent_o[B_RIRR]);
  a_r7_rirr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && wdata_i[B_TRIG] && !rirr_set_i && !rirr_clr_i)
      |=> ent_o[B_RIRR] == $past(ent_o[B_RIRR]));
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_set_i && !(wr_lo_i && !wdata_i[B_TRIG])) |=> ent_o[B_RIRR]);
  a_r11_reeval_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reeval_o |-> (ent_o[B_TRIG] && !ent_o[B_MASK]));
  a_r11_reeval_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reeval_o |-> $past(wr_lo_i || wr_hi_i));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 addr_i,
  input  logic [31:0]                wdata_i,
  input  logic                       we_i,
  input  logic                       re_i,
  output logic [31:0]                rdata_o,
  input  logic [NUM_PINS-1:0]        line_lvl_i,
  input  logic [NUM_PINS-1:0]        rirr_set_i,
  input  logic [NUM_PINS-1:0]        rirr_clr_i,
  output logic [NUM_PINS-1:0][63:0]  entries_o,
  output logic [NUM_PINS-1:0]        reeval_o
);
  localparam logic [7:0] MAX_IDX = 8'(NUM_PINS - 1);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic             d_id, d_ver, d_arb, d_ent, d_hi;
  logic [PIN_W-1:0] d_pin;
  logic             win_we;
  logic [31:0]      win_rd, rd_d;

  irq_redir_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .sel_i(sel_q), .id_o(d_id), .ver_o(d_ver), .arb_o(d_arb),
    .ent_o(d_ent), .hi_o(d_hi), .pin_o(d_pin)
  );

  assign win_we = we_i && (addr_i == OFF_WIN);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = win_we && d_ent && (d_pin == PIN_W'(p));
    irq_redir_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (hit && !d_hi),
      .wr_hi_i   (hit && d_hi),
      .wdata_i   (wdata_i),
      .rirr_set_i(rirr_set_i[p]),
      .rirr_clr_i(rirr_clr_i[p]),
      .line_i    (line_lvl_i[p]),
      .ent_o     (entries_o[p]),
      .reeval_o  (reeval_o[p])
    );
  end

  always_comb begin
    win_rd = '0;
    if (d_id)  win_rd = {4'h0, id_q, 24'h0};
    if (d_ver) win_rd = {8'h00, MAX_IDX, 8'h00, VER_CODE};
    if (d_arb) win_rd = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (d_ent && d_pin == PIN_W'(p))
        win_rd = d_hi ? entries_o[p][63:32] : entries_o[p][31:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_SEL: rd_d = {24'h0, sel_q};
      OFF_WIN: rd_d = win_rd;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      id_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i && addr_i == OFF_SEL) sel_q <= wdata_i[7:0];
      if (win_we && d_id) id_q <= wdata_i[27:24];
      if (re_i) rdata_o <= rd_d;
    end
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  a_r11_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reeval_o));
  a_r2_sel_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_PAD) |=> $stable(sel_q));
endmodule

// File: tb/tb_irq_redir_regs.sv
`timescale 1ns/1ps
module tb_irq_redir_regs;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic we = 0, re = 0;
  logic [N-1:0] line = 0, rset = 0, rclr = 0, reeval;
  logic [N-1:0][63:0] ents;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_redir_regs #(.NUM_PINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .line_lvl_i(line), .rirr_set_i(rset),
    .rirr_clr_i(rclr), .entries_o(ents), .reeval_o(reeval)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk); addr = off; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk); addr = off; re = 1;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic wreg(input logic [7:0] s, input logic [31:0] v);
    wr(8'h00, {24'h0, s}); wr(8'h10, v);
  endtask

  task automatic rreg(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s}); rd(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rdata", rdata, 0);
    chk("R1 reeval", reeval, 0);
    for (int k = 0; k < N; k++) chk("R1 entry", ents[k], 64'h1_0000);
    rd(8'h00, d); chk("R1 selector", d, 0);
  endtask

  task automatic t_selector;
    logic [31:0] d;
    wr(8'h00, 32'h1234_56AB);
    rd(8'h00, d); chk("R2 sel readback", d, 32'hAB);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R2 pad reads 0", d, 0);
    rd(8'h00, d); chk("R2 pad write ignored", d, 32'hAB);
    rd(8'h08, d); chk("R2 other offset", d, 0);
    repeat (3) @(negedge clk);
    chk("R3 rdata held", rdata, 0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    rreg(8'h01, d); chk("R4 version", d, 32'h0017_0011);
    wreg(8'h01, 32'h0); rreg(8'h01, d); chk("R4 version ro", d, 32'h0017_0011);
    wreg(8'h00, 32'hFFFF_FFFF); rreg(8'h00, d); chk("R4 id", d, 32'h0F00_0000);
    wreg(8'h02, 32'hFFFF_FFFF); rreg(8'h02, d); chk("R4 arb", d, 0);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    wreg(8'h1A, 32'hFFFF_FFFF);
    rreg(8'h1A, d); chk("R7 low masks status", d, 32'h0001_AFFF);
    wreg(8'h1B, 32'hFFFF_FFFF);
    rreg(8'h1B, d); chk("R6 high word", d, 32'hFF00_0000);
    chk("R5 export pin5", ents[5], {8'hFF, 39'h0, 17'h1AFFF});
    wreg(8'h3E, 32'h0000_0042); wreg(8'h3F, 32'h5A00_0000);
    chk("R5 last pin", ents[23], {8'h5A, 39'h0, 17'h0_0042});
    wreg(8'h40, 32'h0000_8055); rreg(8'h40, d); chk("R9 pin out of range", d, 0);
    wreg(8'h05, 32'hFFFF_FFFF); rreg(8'h05, d); chk("R9 gap selector", d, 0);
    chk("R9 pin0 untouched", ents[0], 64'h1_0000);
  endtask

  task automatic t_reeval;
    line = 0; line[3] = 1;
    wreg(8'h16, 32'h0000_8020);
    chk("R11 pulse", reeval, 24'h8);
    @(negedge clk); chk("R11 one cycle", reeval, 0);
    wreg(8'h16, 32'h0001_8020); chk("R11 masked", reeval, 0);
    wreg(8'h16, 32'h0000_0020); chk("R11 edge", reeval, 0);
    wreg(8'h16, 32'h0000_8020); @(negedge clk);
    wreg(8'h17, 32'h0100_0000); chk("R11 high half", reeval, 24'h8);
    line = 0;
    wreg(8'h16, 32'h0000_8020); chk("R11 line low", reeval, 0);
  endtask

  task automatic t_rirr;
    wreg(8'h1E, 32'h0000_8030);
    @(negedge clk); rset[7] = 1; @(negedge clk); rset = 0;
    chk("R10 set", ents[7][14], 1);
    wreg(8'h1E, 32'h0000_8031);
    chk("R7 level keeps rirr", ents[7][14], 1);
    chk("R7 vector written", ents[7][7:0], 8'h31);
    wreg(8'h1E, 32'h0000_0031);
    chk("R8 edge clears", ents[7][14], 0);
    @(negedge clk); rset[7] = 1; @(negedge clk); rset = 0;
    @(negedge clk); rclr[7] = 1; @(negedge clk); rclr = 0;
    chk("R10 clear", ents[7][14], 0);
    @(negedge clk); rset[7] = 1; rclr[7] = 1; @(negedge clk); rset = 0; rclr = 0;
    chk("R10 set wins", ents[7][14], 1);
  endtask

  task automatic t_collide;
    wr(8'h00, 32'h22);
    @(negedge clk); addr = 8'h10; wdata = 32'h0000_8040; we = 1; rset[9] = 1;
    @(negedge clk); we = 0; rset = 0;
    chk("R10 same-cycle level", ents[9][14], 1);
    @(negedge clk); addr = 8'h10; wdata = 32'h0000_0040; we = 1; rset[9] = 1;
    @(negedge clk); we = 0; rset = 0;
    chk("R10 same-cycle edge", ents[9][14], 0);
  endtask

  initial begin
    #1 chk("R1 reeval in reset", reeval, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_selector();
    t_fixed();
    t_entry();
    t_reeval();
    t_rirr();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule